// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Output Latency

The block is a synchronous memory with two fully independent access ports, A and B. Either port can read or write any word, and both ports can do so in the same cycle. Each port samples its address, write data and controls on the rising clock edge. It has two enables of opposite polarity, so that banks can be decoded without extra glue. A write-select picks a store or a load. An output enable gates only the output drivers and acts at once, without waiting for a clock edge.

Each port has a static mode input. In flow-through mode, load data is presented in the cycle that follows the sampling edge. In pipelined mode, one more register stage delays it by one further cycle. The output is tri-state in style: a data bus plus a drive flag, with the bus forced to zero whenever the flag is low. Both ports share one clock. The storage is not reset. Only the output and enable registers are reset.

Top module: `dpram_dual`

## Requirements
- R1: A port is selected at an edge only when its low-active enable is 0 and its high-active enable is 1. A deselected port stores nothing, whatever its write-select.
- R2: A selected port with write-select 0 stores its data input at its address on that edge.
- R3: In flow-through mode (mode input 0), a selected load (write-select 1) sampled at edge k drives the addressed word from edge k until edge k+1.
- R4: In pipelined mode (mode input 1), the same load drives its word from edge k+1 until edge k+2, provided the port is also selected at edge k+1.
- R5: A port deselected at edge j does not drive after edge j, in either mode.
- R6: In pipelined mode, after a deselect at edge j the port cannot drive again before edge j+2. It needs a selected load followed by a second selected edge.
- R7: The output enable acts asynchronously. A 1 drops the drive flag at once, without a clock edge. It does not block stores or change the sequencing of loads.
- R8: In flow-through mode the port does not drive in the cycle after a store edge.
- R9: Suppose one port stores to an address at the same edge as the other port loads from it. The load returns the old word, and loads at later edges return the new one. If both ports store to one address at the same edge, port B's data is kept.
- R10: Reset (synchronous, active low) clears both drive flags. Whenever a drive flag is 0, its data bus reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| a_ce_n | input | 1 | Port A enable, active low |
| a_ce | input | 1 | Port A enable, active high |
| a_we_n | input | 1 | Port A write-select: 0 store, 1 load |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_pipe | input | 1 | Port A mode: 0 flow-through, 1 pipelined (static) |
| a_addr | input | ADDR_W | Port A word address |
| a_din | input | DATA_W | Port A store data |
| a_dout | output | DATA_W | Port A load data (zero when not driving) |
| a_drive | output | 1 | Port A output drive flag |
| b_ce_n | input | 1 | Port B enable, active low |
| b_ce | input | 1 | Port B enable, active high |
| b_we_n | input | 1 | Port B write-select: 0 store, 1 load |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_pipe | input | 1 | Port B mode: 0 flow-through, 1 pipelined (static) |
| b_addr | input | ADDR_W | Port B word address |
| b_din | input | DATA_W | Port B store data |
| b_dout | output | DATA_W | Port B load data (zero when not driving) |
| b_drive | output | 1 | Port B output drive flag |

## Verification
The assertions assume that the mode input is held steady around each access they judge. The flow-through properties therefore excuse any edge where the mode has become pipelined. The stimulus changes a mode only while that port has been deselected for two or more cycles. The assertions also assume that every location is stored before it is loaded, since the storage has no reset value. The stimulus fills the whole array through port A before any load or random traffic begins.

// File: rtl/dpram_pkg.sv
// Package: shared helpers for the dual-port RAM.
// Assumes: a port is selected only by the (low, high) enable pair.
package dpram_pkg;
    localparam int NUM_PORTS = 2;

    // Select decode shared by the port controllers and their checks
    function automatic logic port_selected(input logic en_n, input logic en);
        return (!en_n) && en;
    endfunction
endpackage

// File: rtl/dpram_core.sv
// Module: dpram_core
// Storage array with NUM_PORTS access ports on one clock.
// Each port has a registered read word; a read sees the contents from before
// the same-edge store. When two ports store to one address at the same edge,
// the higher-numbered port is kept. The array is not reset.
module dpram_core
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0]             wr,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] din,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store: ports applied in index order, so the highest index wins a clash
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr[p]) begin
                mem[addr[p]] <= din[p];
            end
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
        // Read register: captures the word before this edge's stores land
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_word[g] <= '0;
            end else begin
                rd_word[g] <= mem[addr[g]];
            end
        end
    end

    // R9: a double store to one address keeps the last port's data
    assert_both_store_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr[0] && wr[1] && (addr[0] == addr[1]))
        |=> (mem[$past(addr[1])] == $past(din[1])));
endmodule

// File: rtl/dpram_port.sv
// Module: dpram_port
// Control and output stage of one port. It decodes the select, issues the
// store strobe and tracks the load through flow-through or pipelined output.
// Assumes: pipe is static while the port is in use; oe_n may change at any time.
module dpram_port
    import dpram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              ce,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              pipe,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wr_req,
    output logic [DATA_W-1:0] out_data,
    output logic              out_drive
);
    logic              sel_in;
    logic              rd_req;
    logic              read_q;
    logic              en2_q;
    logic [DATA_W-1:0] data2_q;
    logic              stage_en;
    logic [DATA_W-1:0] stage_data;

    // Decode this edge's request
    always_comb begin
        sel_in = port_selected(ce_n, ce);
        wr_req = sel_in && !we_n;
        rd_req = sel_in && we_n;
    end

    // Track the load and the second (pipelined) stage; stage 2 needs a second select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_q  <= 1'b0;
            en2_q   <= 1'b0;
            data2_q <= '0;
        end else begin
            read_q  <= rd_req;
            en2_q   <= read_q && sel_in;
            data2_q <= rd_word;
        end
    end

    // Choose the latency, then apply the asynchronous output enable
    always_comb begin
        stage_en   = pipe ? en2_q : read_q;
        stage_data = pipe ? data2_q : rd_word;
        out_drive  = stage_en && !oe_n;
        out_data   = out_drive ? stage_data : '0;
    end

    // R3: a flow-through load drives after its edge (unless oe blocks it)
    assert_flow_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && rd_req) |=> (pipe || stage_en));

    // R5: a deselected edge turns the output stage off
    assert_desel_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_in |=> !stage_en);

    // R6: pipelined re-entry needs two selected edges after a deselect
    assert_pipe_reentry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_in |=> ##1 (!pipe || !stage_en));

    // R8: a flow-through store edge leaves the port not driving
    assert_store_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && wr_req) |=> (pipe || !stage_en));

    // R10: an idle bus reads as zero
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_drive |-> (out_data == '0));
endmodule

// File: rtl/dpram_dual.sv
// Module: dpram_dual (top)
// Two-port synchronous RAM with per-port output latency select and an
// asynchronous output enable. Port A is index 0 and port B is index 1 of the core.
// Assumes: one clock for both ports; storage content undefined until stored.
module dpram_dual
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_ce_n,
    input  logic              a_ce,
    input  logic              a_we_n,
    input  logic              a_oe_n,
    input  logic              a_pipe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_drive,
    input  logic              b_ce_n,
    input  logic              b_ce,
    input  logic              b_we_n,
    input  logic              b_oe_n,
    input  logic              b_pipe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_din,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_drive
);
    logic [NUM_PORTS-1:0]             wr;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr;
    logic [NUM_PORTS-1:0][DATA_W-1:0] din;
    logic [NUM_PORTS-1:0][DATA_W-1:0] rd_word;

    // Gather per-port buses for the core
    always_comb begin
        addr[0] = a_addr;
        addr[1] = b_addr;
        din[0]  = a_din;
        din[1]  = b_din;
    end

    dpram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr),
        .addr    (addr),
        .din     (din),
        .rd_word (rd_word)
    );

    dpram_port #(.DATA_W(DATA_W)) u_port_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (a_ce_n),
        .ce        (a_ce),
        .we_n      (a_we_n),
        .oe_n      (a_oe_n),
        .pipe      (a_pipe),
        .rd_word   (rd_word[0]),
        .wr_req    (wr[0]),
        .out_data  (a_dout),
        .out_drive (a_drive)
    );

    dpram_port #(.DATA_W(DATA_W)) u_port_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (b_ce_n),
        .ce        (b_ce),
        .we_n      (b_we_n),
        .oe_n      (b_oe_n),
        .pipe      (b_pipe),
        .rd_word   (rd_word[1]),
        .wr_req    (wr[1]),
        .out_data  (b_dout),
        .out_drive (b_drive)
    );

    // R7: an output disable always wins over the stage state
    assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe_n |-> !a_drive) and (b_oe_n |-> !b_drive));
endmodule

// File: tb/test_dpram_dual.sv
// Bench: behavioural model of both ports, compared after every clock edge.
module test_dpram_dual;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_ce_n = 1'b1, a_ce = 1'b0, a_we_n = 1'b1, a_oe_n = 1'b0, a_pipe = 1'b0;
    logic b_ce_n = 1'b1, b_ce = 1'b0, b_we_n = 1'b1, b_oe_n = 1'b0, b_pipe = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_din = '0, b_din = '0;
    logic [DW-1:0] a_dout, b_dout;
    logic a_drive, b_drive;

    int checks = 0;
    int bad = 0;
    string phase = "R10";

    always #10 clk = ~clk;

    dpram_dual #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_dual (
        .clk(clk), .rst_n(rst_n),
        .a_ce_n(a_ce_n), .a_ce(a_ce), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_pipe(a_pipe),
        .a_addr(a_addr), .a_din(a_din), .a_dout(a_dout), .a_drive(a_drive),
        .b_ce_n(b_ce_n), .b_ce(b_ce), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_pipe(b_pipe),
        .b_addr(b_addr), .b_din(b_din), .b_dout(b_dout), .b_drive(b_drive)
    );

    // Reference model state
    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] m_word [2];
    logic [DW-1:0] m_word2 [2];
    bit            m_load [2];
    bit            m_load2 [2];

    task automatic check(input string req, input string what,
                         input logic [DW:0] act, input logic [DW:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW:0] expect_port(input int p, input bit pipe, input bit oe_n);
        bit on;
        on = (pipe ? m_load2[p] : m_load[p]) && !oe_n;
        return {on, on ? (pipe ? m_word2[p] : m_word[p]) : {DW{1'b0}}};
    endfunction

    // Model update at each edge, then compare both ports a quarter period later
    always @(posedge clk) begin
        bit sel [2];
        bit wen [2];
        int ad [2];
        logic [DW-1:0] dd [2];
        sel[0] = !a_ce_n && a_ce;  wen[0] = !a_we_n;  ad[0] = a_addr;  dd[0] = a_din;
        sel[1] = !b_ce_n && b_ce;  wen[1] = !b_we_n;  ad[1] = b_addr;  dd[1] = b_din;
        for (int p = 0; p < 2; p++) begin
            if (!rst_n) begin
                m_load[p] = 0; m_load2[p] = 0; m_word[p] = '0; m_word2[p] = '0;
            end else begin
                m_load2[p] = m_load[p] && sel[p];
                m_word2[p] = m_word[p];
                m_load[p]  = sel[p] && !wen[p];
                m_word[p]  = m_mem[ad[p]];
            end
        end
        for (int p = 0; p < 2; p++) begin
            if (sel[p] && wen[p]) m_mem[ad[p]] = dd[p];
        end
        #5;
        check(phase, "port A", {a_drive, a_dout}, expect_port(0, a_pipe, a_oe_n));
        check(phase, "port B", {b_drive, b_dout}, expect_port(1, b_pipe, b_oe_n));
    end

    task automatic drive_a(input bit en_n, input bit en, input bit we, input int ad, input int d);
        a_ce_n = en_n; a_ce = en; a_we_n = we; a_addr = AW'(ad); a_din = DW'(d);
    endtask
    task automatic drive_b(input bit en_n, input bit en, input bit we, input int ad, input int d);
        b_ce_n = en_n; b_ce = en; b_we_n = we; b_addr = AW'(ad); b_din = DW'(d);
    endtask
    task automatic step();
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        // R10: reset state
        step(); step();
        check("R10", "reset drive/data", {a_drive, a_dout}, '0);
        check("R10", "reset drive/data B", {b_drive, b_dout}, '0);
        rst_n = 1'b1;
        step();

        // R2: fill the whole array through port A
        phase = "R2";
        for (int i = 0; i < DEPTH; i++) begin
            drive_a(0, 1, 0, i, (i * 37 + 5) & 8'hFF); step();
        end
        drive_a(1, 0, 1, 0, 0); step();

        // R3: flow-through loads on port B
        phase = "R3";
        for (int i = 0; i < 16; i++) begin
            drive_b(0, 1, 1, i * 3, 0); step();
        end
        drive_b(1, 0, 1, 0, 0); step(); step();

        // R4: pipelined loads on port B (mode changed while deselected)
        phase = "R4";
        b_pipe = 1'b1; step(); step();
        for (int i = 0; i < 16; i++) begin
            drive_b(0, 1, 1, 63 - i, 0); step();
        end

        // R5: deselect by each enable, both modes
        phase = "R5";
        drive_b(1, 1, 1, 4, 0); step();
        drive_b(0, 1, 1, 5, 0); step();
        drive_b(0, 0, 1, 6, 0); step();
        drive_b(0, 1, 1, 7, 0); step();
        drive_b(1, 0, 1, 8, 0); step();
        drive_a(0, 1, 1, 9, 0); step();
        drive_a(1, 1, 1, 9, 0); step();

        // R6: pipelined single select after a deselect never drives
        phase = "R6";
        drive_b(1, 0, 1, 0, 0); step(); step();
        drive_b(0, 1, 1, 10, 0); step();
        drive_b(1, 0, 1, 0, 0); step(); step();
        drive_b(0, 1, 1, 11, 0); step();
        drive_b(0, 1, 1, 12, 0); step(); step();

        // R7: output enable acts without a clock, stores still land
        phase = "R7";
        drive_b(0, 1, 1, 13, 0); step(); step();
        #2 b_oe_n = 1'b1; #1;
        check("R7", "async disable", {b_drive, b_dout}, '0);
        drive_b(0, 1, 0, 13, 8'hC3); step();
        drive_b(0, 1, 1, 13, 0); step(); step();
        #2 b_oe_n = 1'b0; #1;
        check("R7", "async enable", {b_drive, b_dout}, {1'b1, 8'hC3});

        // R8: flow-through alternate store/load on port A
        phase = "R8";
        drive_a(1, 0, 1, 0, 0); step(); step();
        for (int i = 0; i < 8; i++) begin
            drive_a(0, 1, 0, 20 + i, 8'h50 + i); step();
            drive_a(0, 1, 1, 20 + i, 0); step();
        end

        // R9: same-edge collisions
        phase = "R9";
        drive_a(0, 1, 0, 30, 8'hAA); drive_b(0, 1, 1, 30, 0); step();
        drive_a(1, 0, 1, 0, 0); step(); step();
        drive_a(0, 1, 0, 31, 8'h11); drive_b(0, 1, 0, 31, 8'h22); step();
        drive_a(0, 1, 1, 31, 0); drive_b(0, 1, 1, 31, 0); step(); step(); step();

        // R1: random traffic on both ports, including deselected stores
        phase = "R1";
        for (int i = 0; i < 400; i++) begin
            drive_a($urandom_range(1), $urandom_range(1), $urandom_range(1),
                    $urandom_range(DEPTH - 1), $urandom_range(255));
            drive_b($urandom_range(1), $urandom_range(1), $urandom_range(1),
                    $urandom_range(DEPTH - 1), $urandom_range(255));
            a_oe_n = ($urandom_range(7) == 0);
            b_oe_n = ($urandom_range(7) == 0);
            step();
        end
        drive_a(1, 0, 1, 0, 0); drive_b(1, 0, 1, 0, 0);
        a_oe_n = 1'b0; b_oe_n = 1'b0;
        step(); step(); step();

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule